// File: doc/BRIEF.md
# Small-Page NAND Flash Device Model

This block is a synthesizable, device-side model of a NAND flash with an 8-bit I/O bus and small pages. A host controller drives it through a command latch enable, an address latch enable, an active-low chip enable, an active-low write protect, a one-cycle write strobe and a one-cycle read strobe. The model decodes the command byte, gathers the address bytes that follow, and runs page read, page program, block erase, read ID, read status and reset. Each page is 512 data bytes followed by 16 spare bytes. The array is kept in registers and is split into erase blocks of `PAGES_PER_BLOCK` pages. The default is 4 pages per block and 2 blocks, which keeps elaboration small. A page-sized buffer sits between the array and the bus.

The controller is a four-state machine. `ST_IDLE` accepts bus cycles. The transition *load-start* (third address byte of a read, page in range) enters `ST_LOAD`, which copies one page into the buffer at one byte per cycle. The transition *program-start* (program confirm, write protect released, page in range, buffer not empty) enters `ST_PROG`, which ANDs the buffer into the array one byte per cycle. The transition *erase-start* (erase confirm, write protect released, page in range) enters `ST_ERASE`, which writes 0xFF to every byte of the block. Each busy state takes the transition *op-done* back to `ST_IDLE` after its last byte. While the machine is busy, `ready` is low and all bus cycles are ignored.

Top module: `snf_flash_model`

## Requirements
- R1: After reset, `ready` is 1 and `dout` is 0x00. Every array byte reads 0xFF. A status read returns 0xC0 while `wp_n` is 1.
- R2: Command 0x00 followed by three address bytes loads the page. The address bytes are, in order: the column, the low page byte, the high page byte. `ready` is 0 in the cycle after the third byte and returns to 1 when the load is done. Each read strobe then updates `dout` at that clock edge with the byte at the column.
- R3: Command 0x01 adds 0x100 to the column. Command 0x50 adds 512 to the column, so a read at column 0 starts in the spare area. All three read commands then read sequentially in the same way.
- R4: Each read advances one byte, first through the 512 data bytes and then through the 16 spare bytes. Once the buffer is exhausted, reads return 0x00.
- R5: Command 0x80 followed by three address bytes clears the buffer count. Data bytes are then collected, up to 528; further bytes are ignored. Command 0x10 ANDs the collected bytes into the page, starting at the column and stopping at the page end.
- R6: When `wp_n` is 0 at the confirm byte (0x10 or 0xD0), program and erase leave the array unchanged.
- R7: Command 0x60, then two page bytes (low byte first), then 0xD0 sets every data and spare byte of the containing block to 0xFF. The page bits below block size are ignored, and other blocks are untouched.
- R8: After 0x70, every read returns the status byte without advancing, until another command is latched. In the status byte, bit 7 is `wp_n`, bit 6 is ready, bit 0 is error (always 0), and the other bits are 0.
- R9: After 0x90 and one address byte, reads return `MAKER_ID`, `DEVICE_ID`, 0xA5 and 0xC0, then 0x00.
- R10: Command 0xFF returns the model to read mode with column offset 0. It clears the address bytes, the address counter and the buffer, so the next read returns 0x00.
- R11: While `ce_n` is 1, write and read strobes have no effect. Every command latch clears the address byte counter.
- R12: A page number of `PAGES_PER_BLOCK*BLOCKS` or more makes read, program and erase do nothing. `ready` stays 1, and a following read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also fills the array with 0xFF |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks a write-strobe byte as a command |
| ale | input | 1 | Marks a write-strobe byte as an address byte |
| wp_n | input | 1 | Write protect, active low |
| wr_stb | input | 1 | One-cycle write strobe for `din` |
| rd_stb | input | 1 | One-cycle read strobe |
| din | input | 8 | Bus byte from the host |
| dout | output | 8 | Byte returned by the last read strobe |
| ready | output | 1 | 1 when idle, 0 during load, program or erase |

## Verification
The bench targets the places where a plausible bug would return a believable but wrong byte. It ANDs a second program into an already-programmed byte: a design that overwrites would return 0x0F instead of 0x0C. It reads after 0x01 at column 1: a design that ignores the offset returns 0xFF instead of the byte at 0x101. It reads the spare area after 0x50 and then reads past the last spare byte: a wrong bound returns stale data instead of 0x00. It aborts an address sequence with a new command, so a counter that is not cleared loads the wrong page. It erases through a page number that is not block-aligned, and it checks that the neighbouring block keeps its data.

// File: rtl/snf_pkg.sv
package snf_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG, ST_ERASE} snf_state_t;
    typedef enum logic [2:0] {M_NONE, M_READ, M_PROG, M_ERASE, M_STAT, M_ID} snf_mode_t;

    localparam logic [7:0] OP_READ_A   = 8'h00;
    localparam logic [7:0] OP_READ_B   = 8'h01;
    localparam logic [7:0] OP_READ_C   = 8'h50;
    localparam logic [7:0] OP_PROG_SET = 8'h80;
    localparam logic [7:0] OP_PROG_GO  = 8'h10;
    localparam logic [7:0] OP_ERS_SET  = 8'h60;
    localparam logic [7:0] OP_ERS_GO   = 8'hD0;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_RESET    = 8'hFF;
    localparam logic [7:0] ID_FILL     = 8'hA5;
    localparam logic [7:0] ID_LAST     = 8'hC0;
endpackage

// File: rtl/snf_cell_array.sv
module snf_cell_array #(
    parameter int DEPTH = 4224,
    parameter int AW    = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata
);
    logic [7:0] mem [DEPTH];

    assign rdata = (32'(raddr) < DEPTH) ? mem[raddr] : 8'hFF;

    // Reset models a freshly erased array (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wen && 32'(waddr) < DEPTH) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/snf_pagebuf.sv
module snf_pagebuf #(
    parameter int DEPTH = 528,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata
);
    logic [7:0] mem [DEPTH];

    assign rdata = (32'(raddr) < DEPTH) ? mem[raddr] : 8'h00;

    always_ff @(posedge clk) begin
        if (wen && 32'(waddr) < DEPTH) mem[waddr] <= wdata;
    end
endmodule

// File: rtl/snf_flash_model.sv
module snf_flash_model #(
    parameter int         DATA_BYTES      = 512,
    parameter int         SPARE_BYTES     = 16,
    parameter int         PAGES_PER_BLOCK = 4,
    parameter int         BLOCKS          = 2,
    parameter logic [7:0] MAKER_ID        = 8'h2C,
    parameter logic [7:0] DEVICE_ID       = 8'h75
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       wp_n,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       ready
);
    import snf_pkg::*;

    localparam int LEN       = DATA_BYTES + SPARE_BYTES;
    localparam int NPAGES    = PAGES_PER_BLOCK * BLOCKS;
    localparam int ARR_BYTES = NPAGES * LEN;
    localparam int BLK_BYTES = PAGES_PER_BLOCK * LEN;
    localparam int LW        = $clog2(LEN + 1);
    localparam int AW        = $clog2(ARR_BYTES);
    localparam int PGW       = $clog2(NPAGES);
    localparam int OPW       = $clog2(BLK_BYTES + 1);
    localparam logic [LW-1:0]  LEN_L     = LW'(LEN);
    localparam logic [LW-1:0]  HALF_OFF  = LW'(256);
    localparam logic [LW-1:0]  SPARE_OFF = LW'(DATA_BYTES);
    localparam logic [PGW-1:0] BLK_MASK  = ~PGW'(PAGES_PER_BLOCK - 1);

    snf_state_t state, state_nx;
    snf_mode_t  mode;
    logic [2:0]     acnt, id_idx;
    logic [7:0]     a_col, a_plo, a_phi;
    logic [LW-1:0]  col_off, rptr, wcnt, prog_room, prog_cnt;
    logic [OPW-1:0] op_idx, op_end;
    logic [15:0]    page_full, page_new;
    logic [PGW-1:0] pg_idx;
    logic [AW-1:0]  page_base, blk_base;
    logic page_ok, bus_on, cmd_we, adr_we, dat_we, rd_go;
    logic start_load, start_prog, start_erase, op_last;

    logic [AW-1:0] arr_raddr, arr_waddr;
    logic [7:0]    arr_rdata, arr_wdata, buf_rdata, buf_wdata;
    logic          arr_wen, buf_wen;
    logic [LW-1:0] buf_raddr, buf_waddr;

    snf_cell_array #(.DEPTH(ARR_BYTES), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .raddr(arr_raddr), .rdata(arr_rdata),
        .wen(arr_wen), .waddr(arr_waddr), .wdata(arr_wdata)
    );

    snf_pagebuf #(.DEPTH(LEN), .AW(LW)) u_pagebuf (
        .clk(clk), .raddr(buf_raddr), .rdata(buf_rdata),
        .wen(buf_wen), .waddr(buf_waddr), .wdata(buf_wdata)
    );

    // bus decode: only while selected and idle
    assign bus_on  = !ce_n && (state == ST_IDLE);
    assign cmd_we  = bus_on && wr_stb && cle;
    assign adr_we  = bus_on && wr_stb && !cle && ale;
    assign dat_we  = bus_on && wr_stb && !cle && !ale;
    assign rd_go   = bus_on && rd_stb;

    assign page_full = {a_phi, a_plo};
    assign page_new  = {din, a_plo};
    assign page_ok   = 32'(page_full) < NPAGES;
    assign pg_idx    = page_full[PGW-1:0];
    assign page_base = AW'(pg_idx) * AW'(LEN);
    assign blk_base  = AW'(pg_idx & BLK_MASK) * AW'(LEN);
    assign prog_room = LEN_L - LW'(a_col);
    assign prog_cnt  = (wcnt < prog_room) ? wcnt : prog_room;
    assign op_last   = (op_idx + OPW'(1)) == op_end;

    assign start_load  = adr_we && mode == M_READ && acnt == 3'd2 && (32'(page_new) < NPAGES);
    assign start_prog  = cmd_we && din == OP_PROG_GO && mode == M_PROG && wp_n && page_ok && prog_cnt != '0;
    assign start_erase = cmd_we && din == OP_ERS_GO && mode == M_ERASE && wp_n && page_ok;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_load)       state_nx = ST_LOAD;
                else if (start_prog)  state_nx = ST_PROG;
                else if (start_erase) state_nx = ST_ERASE;
            end
            ST_LOAD, ST_PROG, ST_ERASE: if (op_last) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and storage ports
    always_comb begin
        ready     = (state == ST_IDLE);
        arr_raddr = page_base + AW'(op_idx);
        arr_wen   = 1'b0;
        arr_waddr = arr_raddr;
        arr_wdata = arr_rdata & buf_rdata;
        buf_raddr = rptr;
        buf_wen   = 1'b0;
        buf_waddr = wcnt;
        buf_wdata = din;
        unique case (state)
            ST_LOAD: begin
                buf_wen   = 1'b1;
                buf_waddr = LW'(op_idx);
                buf_wdata = arr_rdata;
            end
            ST_PROG: begin
                arr_raddr = page_base + AW'(a_col) + AW'(op_idx);
                arr_waddr = arr_raddr;
                buf_raddr = LW'(op_idx);
                arr_wen   = 1'b1;
            end
            ST_ERASE: begin
                arr_wen   = 1'b1;
                arr_waddr = blk_base + AW'(op_idx);
                arr_wdata = 8'hFF;
            end
            default: buf_wen = dat_we && mode == M_PROG && wcnt < LEN_L;
        endcase
    end

    // command, address and read datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= M_READ; col_off <= '0; acnt <= '0; id_idx <= 3'd4;
            a_col <= '0; a_plo <= '0; a_phi <= '0;
            rptr <= LEN_L; wcnt <= '0; op_idx <= '0; op_end <= '0; dout <= '0;
        end else if (state != ST_IDLE) begin
            op_idx <= op_last ? '0 : op_idx + OPW'(1);
        end else begin
            if (cmd_we) begin
                acnt <= '0;
                unique case (din)
                    OP_READ_A:   begin mode <= M_READ; col_off <= '0; end
                    OP_READ_B:   begin mode <= M_READ; col_off <= HALF_OFF; end
                    OP_READ_C:   begin mode <= M_READ; col_off <= SPARE_OFF; end
                    OP_PROG_SET: mode <= M_PROG;
                    OP_ERS_SET:  mode <= M_ERASE;
                    OP_STATUS:   mode <= M_STAT;
                    OP_IDENT:    begin mode <= M_ID; id_idx <= 3'd4; end
                    OP_PROG_GO:  begin
                        mode <= M_NONE;
                        op_idx <= '0; op_end <= OPW'(prog_cnt);
                    end
                    OP_ERS_GO:   begin
                        mode <= M_NONE;
                        op_idx <= '0; op_end <= OPW'(BLK_BYTES);
                    end
                    OP_RESET:    begin
                        mode <= M_READ; col_off <= '0;
                        a_col <= '0; a_plo <= '0; a_phi <= '0;
                        rptr <= LEN_L; wcnt <= '0;
                    end
                    default:     mode <= M_NONE;
                endcase
            end else if (adr_we) begin
                if (mode == M_ERASE) begin
                    if (acnt == 3'd0) a_plo <= din;
                    if (acnt == 3'd1) a_phi <= din;
                end else begin
                    if (acnt == 3'd0) a_col <= din;
                    if (acnt == 3'd1) a_plo <= din;
                    if (acnt == 3'd2) a_phi <= din;
                end
                if (acnt != 3'd7) acnt <= acnt + 3'd1;
                if (mode == M_ID && acnt == 3'd0) id_idx <= '0;
                if (mode == M_PROG && acnt == 3'd2) wcnt <= '0;
                if (mode == M_READ && acnt == 3'd2) begin
                    rptr   <= start_load ? LW'(a_col) + col_off : LEN_L;
                    op_idx <= '0;
                    op_end <= OPW'(LEN);
                end
            end else if (dat_we && mode == M_PROG && wcnt < LEN_L) begin
                wcnt <= wcnt + LW'(1);
            end
            if (rd_go) begin
                unique case (mode)
                    M_STAT: dout <= {wp_n, ready, 6'b0};
                    M_ID: begin
                        unique case (id_idx)
                            3'd0:    dout <= MAKER_ID;
                            3'd1:    dout <= DEVICE_ID;
                            3'd2:    dout <= ID_FILL;
                            3'd3:    dout <= ID_LAST;
                            default: dout <= 8'h00;
                        endcase
                        if (id_idx < 3'd4) id_idx <= id_idx + 3'd1;
                    end
                    M_READ: begin
                        if (rptr < LEN_L) begin
                            dout <= buf_rdata;
                            rptr <= rptr + LW'(1);
                        end else begin
                            dout <= 8'h00;
                        end
                    end
                    default: dout <= 8'h00;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    assert_rptr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rptr <= LEN_L) else $error("read pointer past page end");

    assert_wcnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= LEN_L) else $error("program count past page end");

    assert_status_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && mode == M_STAT) |=> dout == {$past(wp_n), 1'b1, 6'b0})
        else $error("status byte wrong");

    assert_wp_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PROG || state == ST_ERASE) && $past(state) == ST_IDLE) |-> $past(wp_n))
        else $error("array change started while write protected");

    assert_ce_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> ($stable(mode) && $stable(acnt)))
        else $error("deselected bus cycle changed state");

    assert_load_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOAD |-> 32'(page_full) < NPAGES)
        else $error("load of page beyond array");

    assert_busy_after_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !ce_n && wr_stb && ale && !cle && mode == M_READ && acnt == 3'd2
         && 32'({din, a_plo}) < NPAGES) |=> !ready)
        else $error("no busy after third read address byte");
endmodule

// File: tb/snf_flash_model_bench.sv
module snf_flash_model_bench;
    localparam logic [3:0] K_CMD = 4'd0, K_ADR = 4'd1, K_WR = 4'd2, K_RD = 4'd3,
                           K_WAIT = 4'd4, K_WP = 4'd5, K_CE = 4'd6;
    localparam int N = 126;
    localparam int LIMIT = 150000;

    // {op, requirement number, value, expected}
    localparam logic [23:0] SCRIPT [N] = '{
        // R8 status repeats
        {K_CMD,4'd8,8'h70,8'h00}, {K_RD,4'd8,8'h00,8'hC0}, {K_RD,4'd8,8'h00,8'hC0},
        // R9 identification
        {K_CMD,4'd9,8'h90,8'h00}, {K_ADR,4'd9,8'h00,8'h00}, {K_RD,4'd9,8'h00,8'h2C},
        {K_RD,4'd9,8'h00,8'h75}, {K_RD,4'd9,8'h00,8'hA5}, {K_RD,4'd9,8'h00,8'hC0},
        {K_RD,4'd9,8'h00,8'h00},
        // R5 program page 1 column 4
        {K_CMD,4'd5,8'h80,8'h00}, {K_ADR,4'd5,8'h04,8'h00}, {K_ADR,4'd5,8'h01,8'h00},
        {K_ADR,4'd5,8'h00,8'h00}, {K_WR,4'd5,8'h3C,8'h00}, {K_WR,4'd5,8'hA5,8'h00},
        {K_CMD,4'd5,8'h10,8'h00}, {K_WAIT,4'd5,8'h00,8'h00},
        // R2 read page 1 from column 3
        {K_CMD,4'd2,8'h00,8'h00}, {K_ADR,4'd2,8'h03,8'h00}, {K_ADR,4'd2,8'h01,8'h00},
        {K_ADR,4'd2,8'h00,8'h00}, {K_WAIT,4'd2,8'h00,8'h00}, {K_RD,4'd2,8'h00,8'hFF},
        {K_RD,4'd2,8'h00,8'h3C}, {K_RD,4'd2,8'h00,8'hA5}, {K_RD,4'd2,8'h00,8'hFF},
        // R5 second program ANDs 0x0F into 0x3C
        {K_CMD,4'd5,8'h80,8'h00}, {K_ADR,4'd5,8'h04,8'h00}, {K_ADR,4'd5,8'h01,8'h00},
        {K_ADR,4'd5,8'h00,8'h00}, {K_WR,4'd5,8'h0F,8'h00}, {K_CMD,4'd5,8'h10,8'h00},
        {K_WAIT,4'd5,8'h00,8'h00}, {K_CMD,4'd5,8'h00,8'h00}, {K_ADR,4'd5,8'h04,8'h00},
        {K_ADR,4'd5,8'h01,8'h00}, {K_ADR,4'd5,8'h00,8'h00}, {K_WAIT,4'd5,8'h00,8'h00},
        {K_RD,4'd5,8'h00,8'h0C},
        // R3 second-half read: program 0xFF..0x101 of page 2, read at 0x01+0x100
        {K_CMD,4'd3,8'h80,8'h00}, {K_ADR,4'd3,8'hFF,8'h00}, {K_ADR,4'd3,8'h02,8'h00},
        {K_ADR,4'd3,8'h00,8'h00}, {K_WR,4'd3,8'h11,8'h00}, {K_WR,4'd3,8'h22,8'h00},
        {K_WR,4'd3,8'h33,8'h00}, {K_CMD,4'd3,8'h10,8'h00}, {K_WAIT,4'd3,8'h00,8'h00},
        {K_CMD,4'd3,8'h01,8'h00}, {K_ADR,4'd3,8'h01,8'h00}, {K_ADR,4'd3,8'h02,8'h00},
        {K_ADR,4'd3,8'h00,8'h00}, {K_WAIT,4'd3,8'h00,8'h00}, {K_RD,4'd3,8'h00,8'h33},
        {K_RD,4'd3,8'h00,8'hFF},
        // R6 / R8 write protect blocks a program, status bit 7 low
        {K_WP,4'd6,8'h00,8'h00}, {K_CMD,4'd8,8'h70,8'h00}, {K_RD,4'd8,8'h00,8'h40},
        {K_CMD,4'd6,8'h80,8'h00}, {K_ADR,4'd6,8'h04,8'h00}, {K_ADR,4'd6,8'h01,8'h00},
        {K_ADR,4'd6,8'h00,8'h00}, {K_WR,4'd6,8'h00,8'h00}, {K_CMD,4'd6,8'h10,8'h00},
        {K_WAIT,4'd6,8'h00,8'h00}, {K_CMD,4'd6,8'h00,8'h00}, {K_ADR,4'd6,8'h04,8'h00},
        {K_ADR,4'd6,8'h01,8'h00}, {K_ADR,4'd6,8'h00,8'h00}, {K_WAIT,4'd6,8'h00,8'h00},
        {K_RD,4'd6,8'h00,8'h0C},
        // R11 deselected status command is ignored, read continues at column 5
        {K_CE,4'd11,8'h01,8'h00}, {K_CMD,4'd11,8'h70,8'h00}, {K_CE,4'd11,8'h00,8'h00},
        {K_RD,4'd11,8'h00,8'hA5},
        // R11 command latch clears the address counter
        {K_CMD,4'd11,8'h00,8'h00}, {K_ADR,4'd11,8'h09,8'h00}, {K_ADR,4'd11,8'h09,8'h00},
        {K_CMD,4'd11,8'h00,8'h00}, {K_ADR,4'd11,8'h04,8'h00}, {K_ADR,4'd11,8'h01,8'h00},
        {K_ADR,4'd11,8'h00,8'h00}, {K_WAIT,4'd11,8'h00,8'h00}, {K_RD,4'd11,8'h00,8'h0C},
        // R6 erase inhibited while protected
        {K_CMD,4'd6,8'h60,8'h00}, {K_ADR,4'd6,8'h01,8'h00}, {K_ADR,4'd6,8'h00,8'h00},
        {K_CMD,4'd6,8'hD0,8'h00}, {K_WAIT,4'd6,8'h00,8'h00}, {K_CMD,4'd6,8'h00,8'h00},
        {K_ADR,4'd6,8'h04,8'h00}, {K_ADR,4'd6,8'h01,8'h00}, {K_ADR,4'd6,8'h00,8'h00},
        {K_WAIT,4'd6,8'h00,8'h00}, {K_RD,4'd6,8'h00,8'h0C},
        // R7 erase through page 3 clears page 1 of the same block
        {K_WP,4'd7,8'h01,8'h00}, {K_CMD,4'd7,8'h60,8'h00}, {K_ADR,4'd7,8'h03,8'h00},
        {K_ADR,4'd7,8'h00,8'h00}, {K_CMD,4'd7,8'hD0,8'h00}, {K_WAIT,4'd7,8'h00,8'h00},
        {K_CMD,4'd7,8'h00,8'h00}, {K_ADR,4'd7,8'h04,8'h00}, {K_ADR,4'd7,8'h01,8'h00},
        {K_ADR,4'd7,8'h00,8'h00}, {K_WAIT,4'd7,8'h00,8'h00}, {K_RD,4'd7,8'h00,8'hFF},
        // R12 page 8 is beyond the array
        {K_CMD,4'd12,8'h80,8'h00}, {K_ADR,4'd12,8'h00,8'h00}, {K_ADR,4'd12,8'h08,8'h00},
        {K_ADR,4'd12,8'h00,8'h00}, {K_WR,4'd12,8'h00,8'h00}, {K_CMD,4'd12,8'h10,8'h00},
        {K_WAIT,4'd12,8'h00,8'h00}, {K_CMD,4'd12,8'h00,8'h00}, {K_ADR,4'd12,8'h00,8'h00},
        {K_ADR,4'd12,8'h08,8'h00}, {K_ADR,4'd12,8'h00,8'h00}, {K_WAIT,4'd12,8'h00,8'h00},
        {K_RD,4'd12,8'h00,8'h00},
        // R10 reset command
        {K_CMD,4'd10,8'h70,8'h00}, {K_CMD,4'd10,8'hFF,8'h00}, {K_RD,4'd10,8'h00,8'h00},
        {K_CMD,4'd10,8'h70,8'h00}, {K_RD,4'd10,8'h00,8'hC0}
    };

    logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b0, cle = 1'b0, ale = 1'b0;
    logic wp_n = 1'b1, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic ready;
    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    snf_flash_model u_snf_flash_model (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout), .ready(ready)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i * 7 + 3);
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic bus(input logic c, input logic a, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        cle = c; ale = a; wr_stb = w; rd_stb = r; din = d;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic wait_rdy(input string tag);
        int n;
        n = 0;
        while (!ready && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!ready) check(tag, 8'(ready), 8'h01);
    endtask

    task automatic cmd3(input logic [7:0] c, input logic [7:0] col, input logic [7:0] pg);
        bus(1, 0, 1, 0, c);
        bus(0, 1, 1, 0, col);
        bus(0, 1, 1, 0, pg);
        bus(0, 1, 1, 0, 8'h00);
    endtask

    task automatic erase(input logic [7:0] pg);
        bus(1, 0, 1, 0, 8'h60);
        bus(0, 1, 1, 0, pg);
        bus(0, 1, 1, 0, 8'h00);
        bus(1, 0, 1, 0, 8'hD0);
        wait_rdy("R7");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] e;
        int errs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 8'(ready), 8'h01);
        check("R1 dout", dout, 8'h00);
        // R2 busy after third address byte, R1 erased content
        cmd3(8'h00, 8'h00, 8'h00);
        check("R2 busy", 8'(ready), 8'h00);
        wait_rdy("R2");
        for (int i = 0; i < 3; i++) begin
            bus(0, 0, 0, 1, 8'h00);
            check("R1 erased", dout, 8'hFF);
        end

        for (int k = 0; k < N; k++) begin
            e = SCRIPT[k];
            unique case (e[23:20])
                K_CMD:  bus(1, 0, 1, 0, e[15:8]);
                K_ADR:  bus(0, 1, 1, 0, e[15:8]);
                K_WR:   bus(0, 0, 1, 0, e[15:8]);
                K_RD:   begin
                    bus(0, 0, 0, 1, 8'h00);
                    check($sformatf("R%0d step %0d", e[19:16], k), dout, e[7:0]);
                end
                K_WAIT: wait_rdy($sformatf("R%0d step %0d", e[19:16], k));
                K_WP:   wp_n = e[8];
                K_CE:   ce_n = e[8];
                default: ;
            endcase
        end

        // R5 full page program into page 4 (block 1), two extra bytes dropped
        cmd3(8'h80, 8'h00, 8'h04);
        for (int i = 0; i < 530; i++) bus(0, 0, 1, 0, (i < 528) ? pat(i) : 8'h00);
        bus(1, 0, 1, 0, 8'h10);
        wait_rdy("R5");
        // R3 spare read at column 0 after 0x50, R4 exhaustion
        cmd3(8'h50, 8'h00, 8'h04);
        wait_rdy("R3");
        errs = 0;
        for (int i = 0; i < 16; i++) begin
            bus(0, 0, 0, 1, 8'h00);
            if (dout !== pat(512 + i)) errs++;
        end
        check("R3 spare area", 8'(errs), 8'h00);
        bus(0, 0, 0, 1, 8'h00);
        check("R4 past spare", dout, 8'h00);
        // R4 sequential read through data and spare
        cmd3(8'h00, 8'h00, 8'h04);
        wait_rdy("R4");
        errs = 0;
        for (int i = 0; i < 528; i++) begin
            bus(0, 0, 0, 1, 8'h00);
            if (dout !== pat(i)) errs++;
        end
        check("R4 whole page", 8'(errs), 8'h00);
        bus(0, 0, 0, 1, 8'h00);
        check("R4 exhausted", dout, 8'h00);
        // R7 erase of block 0 leaves block 1 intact
        erase(8'h00);
        cmd3(8'h00, 8'h00, 8'h04);
        wait_rdy("R7");
        bus(0, 0, 0, 1, 8'h00);
        check("R7 other block kept", dout, pat(0));
        // R7 erase through page 6 clears spare of page 4
        erase(8'h06);
        cmd3(8'h50, 8'h00, 8'h04);
        wait_rdy("R7");
        bus(0, 0, 0, 1, 8'h00);
        check("R7 spare erased", dout, 8'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule